// File: doc/BRIEF.md
# TDM Loopback and Compare Router

The router sits between the serial TDM pins of a line interface and the internal serial transmit and receive channel paths. It takes one serial input stream from the pins (`in0`) and two internal transmit streams (`tx0`, `tx1`). From these it produces one receive stream into the channel memory (`rx0`) and two output pin streams (`out0`, `out1`). Every stream moves one bit per `bit_en` strobe. A `frame_start` strobe, raised together with `bit_en`, marks the first bit of each frame.

A 4-bit routing setting is written through a small byte-wide port. Bits [1:0] choose a loopback topology among `in0`, `out0`, `tx0` and `rx0`. Bits [3:2] choose what `out1` carries: the plain `tx1` stream, `in0` delayed by one frame, `in0` XOR `tx1`, or `in0` XOR the same input one frame earlier. The one-frame copy comes from an internal shift line. That line is 32 channels × 8 bits at default parameters, or 24 channels when `chan24` is high. A written setting takes effect only at the next frame boundary, so a frame never carries a mix of two routings.

Top module: `tdm_loop_router`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `bit_en`, `out0`, `out1` and `rx0` are 0 and `cfg_rdata` is 0. The active routing after reset is code 0 in both fields.
- R2: Each bit is registered: the value computed from the inputs at a clock edge with `bit_en` high appears on the outputs after that edge. With loop code 00 (`cfg[1:0]`), `out0` = `tx0` and `rx0` = `in0`.
- R3: With loop code 01, `out0` = `in0` and `rx0` = `in0`.
- R4: With loop code 10, `out0` = `tx0` and `rx0` = `tx0`, and `in0` is not received.
- R5: With loop code 11, `out0` = `in0` and `rx0` = `tx0`.
- R6: With output-1 code 00 (`cfg[3:2]`), `out1` = `tx1`.
- R7: With output-1 code 01, `out1` is the `in0` bit from exactly one frame earlier: CHANNELS×CH_BITS bits before when `chan24` is low. Bits from before reset count as 0.
- R8: With output-1 code 10, `out1` = `in0` XOR `tx1`.
- R9: With output-1 code 11, `out1` = `in0` XOR (`in0` one frame earlier).
- R10: When `chan24` is high at a frame start, the frame length and the delay for that frame are CH_ALT×CH_BITS bits.
- R11: `cfg_rdata[3:0]` returns the last value written to `cfg_wdata[3:0]`. `cfg_rdata[7:4]` always reads 0, and writes to bits 7..4 have no effect on routing.
- R12: A written setting, and the level of `chan24`, take effect starting at the bit that carries `frame_start`. Bits before it keep the previous routing.
- R13: When `bit_en` is low, `out0`, `out1` and `rx0` hold their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit is taken and produced per cycle this is high |
| frame_start | input | 1 | High with `bit_en` on the first bit of a frame |
| chan24 | input | 1 | Selects the shorter (CH_ALT channel) frame, sampled at frame start |
| cfg_we | input | 1 | Write strobe for the routing setting |
| cfg_wdata | input | 8 | Write data; bits [1:0] loop code, bits [3:2] output-1 code |
| cfg_rdata | output | 8 | Readback of the written setting, upper nibble zero |
| in0 | input | 1 | Serial input stream from the pin |
| tx0 | input | 1 | Serial transmit path 0 from channel memory |
| tx1 | input | 1 | Serial transmit path 1 from channel memory |
| out0 | output | 1 | Serial output stream 0 to the pin |
| out1 | output | 1 | Serial output stream 1 to the pin |
| rx0 | output | 1 | Serial receive path 0 to channel memory |

## Verification
The bench builds the router with CHANNELS=4, CH_ALT=3 and CH_BITS=8, which gives 32-bit and 24-bit frames. With frames that short, all sixteen routing settings can be run in both frame lengths, with several whole frames each. It also brings the one-frame delay and the frame-to-frame XOR, whose window is a full frame, within a few hundred cycles. Inputs come from a bench LFSR. Each setting is written mid-frame, so the bits before the next boundary check that the old routing is kept. The expected delayed bit is read from a history of every `in0` bit driven since reset.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

  typedef enum logic [1:0] {
    LOOP_NONE    = 2'b00,
    LOOP_PIN     = 2'b01,
    LOOP_TX_RX   = 2'b10,
    LOOP_CROSS   = 2'b11
  } loop_mode_e;

  typedef enum logic [1:0] {
    O1_TX        = 2'b00,
    O1_DELAY     = 2'b01,
    O1_TX_CMP    = 2'b10,
    O1_FRAME_CMP = 2'b11
  } out1_mode_e;

  typedef struct packed {
    out1_mode_e o1;
    loop_mode_e loop;
  } route_cfg_t;

  localparam int CFG_W  = 4;
  localparam int REG_W  = 8;

endpackage

// File: rtl/tdm_route_ctrl.sv
module tdm_route_ctrl
  import tdm_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  input  logic             chan24,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output route_cfg_t       eff_cfg,
  output logic             eff_ch24
);

  route_cfg_t pend_q, pend_d;
  route_cfg_t act_q,  act_d;
  logic       ch24_q, ch24_d;
  logic       frame_tick;

  assign frame_tick = bit_en & frame_start;

  always_comb begin
    pend_d = pend_q;
    if (cfg_we) begin
      pend_d = route_cfg_t'(cfg_wdata[CFG_W-1:0]);
    end
  end

  always_comb begin
    act_d  = act_q;
    ch24_d = ch24_q;
    if (frame_tick) begin
      act_d  = pend_q;
      ch24_d = chan24;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      ch24_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      ch24_q <= ch24_d;
    end
  end

  assign eff_cfg   = frame_tick ? pend_q : act_q;
  assign eff_ch24  = frame_tick ? chan24 : ch24_q;
  assign cfg_rdata = {{(REG_W-CFG_W){1'b0}}, pend_q};

  AST_SWITCH_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_q) && $stable(ch24_q)); // R12

  AST_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[REG_W-1:CFG_W] != '0)) |=> (cfg_rdata[REG_W-1:CFG_W] == '0)); // R11

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata[CFG_W-1:0] == $past(cfg_wdata[CFG_W-1:0]))); // R11

endmodule

// File: rtl/tdm_frame_delay.sv
module tdm_frame_delay #(
  parameter int CHANNELS = 32,
  parameter int CH_ALT   = 24,
  parameter int CH_BITS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic ch24,
  input  logic din,
  output logic dly_bit
);

  localparam int LEN     = CHANNELS * CH_BITS;
  localparam int ALT_LEN = CH_ALT * CH_BITS;

  logic [LEN-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (bit_en) begin
      line_d = {line_q[LEN-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  generate
    if (ALT_LEN == LEN) begin : g_single_tap
      logic unused_sel;
      assign unused_sel = ch24;
      assign dly_bit    = line_q[LEN-1];
    end else begin : g_dual_tap
      assign dly_bit = ch24 ? line_q[ALT_LEN-1] : line_q[LEN-1];
    end
  endgenerate

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_q)); // R13

  AST_LINE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (line_q[0] == $past(din))); // R7

endmodule

// File: rtl/tdm_route_mux.sv
module tdm_route_mux
  import tdm_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  route_cfg_t eff_cfg,
  input  logic       in0,
  input  logic       tx0,
  input  logic       tx1,
  input  logic       dly_bit,
  output logic       out0,
  output logic       out1,
  output logic       rx0
);

  logic out0_q, out0_d;
  logic out1_q, out1_d;
  logic rx0_q,  rx0_d;
  logic out0_sel, rx0_sel, out1_sel;

  always_comb begin
    case (eff_cfg.loop)
      LOOP_NONE:  begin out0_sel = tx0; rx0_sel = in0; end
      LOOP_PIN:   begin out0_sel = in0; rx0_sel = in0; end
      LOOP_TX_RX: begin out0_sel = tx0; rx0_sel = tx0; end
      default:    begin out0_sel = in0; rx0_sel = tx0; end
    endcase
  end

  always_comb begin
    case (eff_cfg.o1)
      O1_TX:     out1_sel = tx1;
      O1_DELAY:  out1_sel = dly_bit;
      O1_TX_CMP: out1_sel = in0 ^ tx1;
      default:   out1_sel = in0 ^ dly_bit;
    endcase
  end

  always_comb begin
    out0_d = out0_q;
    out1_d = out1_q;
    rx0_d  = rx0_q;
    if (bit_en) begin
      out0_d = out0_sel;
      out1_d = out1_sel;
      rx0_d  = rx0_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_q <= 1'b0;
      out1_q <= 1'b0;
      rx0_q  <= 1'b0;
    end else begin
      out0_q <= out0_d;
      out1_q <= out1_d;
      rx0_q  <= rx0_d;
    end
  end

  assign out0 = out0_q;
  assign out1 = out1_q;
  assign rx0  = rx0_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({out0, out1, rx0})); // R13

  AST_LOOP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && eff_cfg.loop == LOOP_PIN) |=> (out0 == $past(in0)) && (rx0 == $past(in0))); // R3

  AST_LOOP_TX_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && eff_cfg.loop == LOOP_TX_RX) |=> (rx0 == $past(tx0)) && (out0 == $past(tx0))); // R4

  AST_OUT1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && eff_cfg.o1 == O1_TX) |=> (out1 == $past(tx1))); // R6

  AST_OUT1_TXCMP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && eff_cfg.o1 == O1_TX_CMP) |=> (out1 == ($past(in0) ^ $past(tx1)))); // R8

endmodule

// File: rtl/tdm_loop_router.sv
module tdm_loop_router
  import tdm_route_pkg::*;
#(
  parameter int CHANNELS = 32,
  parameter int CH_ALT   = 24,
  parameter int CH_BITS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_start,
  input  logic       chan24,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       in0,
  input  logic       tx0,
  input  logic       tx1,
  output logic       out0,
  output logic       out1,
  output logic       rx0
);

  route_cfg_t eff_cfg;
  logic       eff_ch24;
  logic       dly_bit;

  tdm_route_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .chan24      (chan24),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .eff_cfg     (eff_cfg),
    .eff_ch24    (eff_ch24)
  );

  tdm_frame_delay #(
    .CHANNELS (CHANNELS),
    .CH_ALT   (CH_ALT),
    .CH_BITS  (CH_BITS)
  ) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .ch24    (eff_ch24),
    .din     (in0),
    .dly_bit (dly_bit)
  );

  tdm_route_mux u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .eff_cfg (eff_cfg),
    .in0     (in0),
    .tx0     (tx0),
    .tx1     (tx1),
    .dly_bit (dly_bit),
    .out0    (out0),
    .out1    (out1),
    .rx0     (rx0)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && $rose(rst_n)) |-> (!out0 && !out1 && !rx0)); // R1

endmodule

// File: tb/sim_tdm_loop_router.sv
`timescale 1ns/1ps
module sim_tdm_loop_router;

  localparam int NCH = 4;
  localparam int NALT = 3;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, bit_en, frame_start, chan24, cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       in0, tx0, tx1, out0, out1, rx0;

  tdm_loop_router #(.CHANNELS(NCH), .CH_ALT(NALT), .CH_BITS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .chan24(chan24), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in0(in0), .tx0(tx0), .tx1(tx1), .out0(out0), .out1(out1), .rx0(rx0)
  );

  int checks = 0;
  int errors = 0;
  bit hist [0:16383];
  int k = 0;
  int pos = 0;
  int flen = NCH * NB;
  logic [3:0]  m_pend = 4'h0;
  logic [3:0]  m_act  = 4'h0;
  bit          m_ch24 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic chk8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string loop_tag(input logic [1:0] c);
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string o1_tag(input logic [1:0] c, input bit c24);
    if (c24 && c[0]) return "R10";
    case (c)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic step_bit();
    logic d, e0, e1, er;
    string t0, t1;
    @(negedge clk);
    next_rand();
    in0 = lfsr[0]; tx0 = lfsr[3]; tx1 = lfsr[7];
    bit_en = 1'b1;
    frame_start = (pos == 0);
    if (pos == 0) begin
      m_act  = m_pend;
      m_ch24 = chan24;
      flen   = (m_ch24 ? NALT : NCH) * NB;
    end
    d = (k >= flen) ? hist[k - flen] : 1'b0;
    hist[k] = in0;
    case (m_act[1:0])
      2'b00: begin e0 = tx0; er = in0; end
      2'b01: begin e0 = in0; er = in0; end
      2'b10: begin e0 = tx0; er = tx0; end
      default: begin e0 = in0; er = tx0; end
    endcase
    case (m_act[3:2])
      2'b00: e1 = tx1;
      2'b01: e1 = d;
      2'b10: e1 = in0 ^ tx1;
      default: e1 = in0 ^ d;
    endcase
    if (m_pend != m_act) begin
      t0 = "R12"; t1 = "R12";
    end else begin
      t0 = loop_tag(m_act[1:0]);
      t1 = o1_tag(m_act[3:2], m_ch24);
    end
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    frame_start = 1'b0;
    chk(t0, "out0", out0, e0);
    chk(t0, "rx0", rx0, er);
    chk(t1, "out1", out1, e1);
    k++;
    pos++;
    if (pos == flen) pos = 0;
    next_rand();
    in0 = lfsr[1]; tx0 = lfsr[4]; tx1 = lfsr[9];
    @(posedge clk);
    @(negedge clk);
    chk("R13", "out0 idle", out0, e0);
    chk("R13", "rx0 idle", rx0, er);
    chk("R13", "out1 idle", out1, e1);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    m_pend = v[3:0];
    chk8("R11", "cfg_rdata", cfg_rdata, {4'h0, v[3:0]});
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired checks=%0d expected completion", checks);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frame_start = 1'b0; chan24 = 1'b0;
    cfg_we = 1'b0; cfg_wdata = 8'h00; in0 = 1'b1; tx0 = 1'b1; tx1 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out0 in reset", out0, 1'b0);
    chk("R1", "out1 in reset", out1, 1'b0);
    chk("R1", "rx0 in reset", rx0, 1'b0);
    chk8("R1", "cfg_rdata in reset", cfg_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "out0 after reset", out0, 1'b0);
    chk("R1", "out1 after reset", out1, 1'b0);
    chk("R1", "rx0 after reset", rx0, 1'b0);

    for (int c24 = 0; c24 < 2; c24++) begin
      chan24 = c24[0];
      for (int code = 0; code < 16; code++) begin
        while (pos != 5) step_bit();
        write_cfg({(code[0] ? 4'hF : 4'h0), code[3:0]});
        while (pos != 0) step_bit();
        repeat (2 * flen) step_bit();
      end
    end

    write_cfg({4'hA, 4'b1101});
    while (pos != 0) step_bit();
    repeat (flen) step_bit();
    write_cfg({4'h5, 4'b1101});
    chk8("R11", "upper nibble write only", cfg_rdata, 8'h0D);
    repeat (flen + 3) step_bit();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule